// File: doc/BRIEF.md
# Bit Count and Packed Lane Unit

This unit handles the bit-counting and small-integer media operations of a 64-bit integer datapath. Each cycle it takes two 64-bit operands, a 7-bit function code and a qualifier that says whether the instruction's first source field names hard-wired register 31. It produces one 64-bit result and an illegal-function flag. Both are registered, so they appear one clock after the inputs are sampled.

The function set has several groups. Population count, leading-zero count and trailing-zero count work on operand B. A sum of absolute byte differences reduces eight byte lanes of A and B. Lanewise minimum and maximum work on eight bytes or four 16-bit words, either signed or unsigned. Byte unpack and pack spread or gather byte lanes of B. Sign extension of B's low byte or low halfword is legal only when the register-31 qualifier is set.

A function code the unit does not know produces a zero result with the illegal flag raised. A sign extension issued without the qualifier is treated the same way.

Top module: `bcu_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the next value of result is zero and the next value of illegal is 0.
- R2: Function 0x30 returns the number of 1 bits in op_b.
- R3: Function 0x32 returns the number of zero bits above the most significant 1 of op_b, and 64 when op_b is zero.
- R4: Function 0x33 returns the number of zero bits below the least significant 1 of op_b, and 64 when op_b is zero.
- R5: Function 0x31 returns the sum over byte lanes 0..7 (lane k is bits 8k+7:8k) of the unsigned absolute difference between op_a's and op_b's bytes.
- R6: Functions 0x38, 0x39, 0x3a and 0x3b return, lane by lane, the smaller of op_a and op_b for signed bytes, signed 16-bit words, unsigned bytes and unsigned words respectively.
- R7: Functions 0x3c, 0x3d, 0x3e and 0x3f return, lane by lane, the larger value for unsigned bytes, unsigned words, signed bytes and signed words respectively.
- R8: Function 0x34 puts op_b bytes 0..3 into result bits 7:0, 23:16, 39:32 and 55:48, with all other bits zero. Function 0x35 puts op_b byte 0 at bits 7:0 and byte 1 at bits 39:32, with all other bits zero.
- R9: Function 0x36 places op_b bytes 0, 2, 4 and 6 into result bytes 0, 1, 2 and 3. Function 0x37 places op_b bytes 0 and 4 into result bytes 0 and 1. All other result bits are zero.
- R10: With a_is_r31 high, function 0x00 returns op_b[7:0] sign-extended to 64 bits and function 0x01 returns op_b[15:0] sign-extended to 64 bits.
- R11: Functions 0x00 or 0x01 with a_is_r31 low, and any code outside 0x00, 0x01 and 0x30..0x3f, return result zero with illegal = 1. Every legal function returns illegal = 0.
- R12: Result and illegal reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| func | input | 7 | Function code |
| a_is_r31 | input | 1 | First source field names register 31 |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-function flag |

## Verification
The assertions check the following on every cycle:
- An illegal flag always comes with a zero result.
- A population count never exceeds 64.
- A zero operand gives 64 for both zero counts.
- A sum of differences stays within eight times 255.
- Sign-extended results have uniform upper bits.

Exact lane values need the bench's reference functions, run over random and directed operands:
- min/max ties and signed-versus-unsigned lane boundaries;
- exact leading and trailing zero counts at single-bit positions;
- pack and unpack byte placement.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int DATA_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int FUNC_W  = 7;
    localparam int NUM_B   = DATA_W / BYTE_W;
    localparam int NUM_W   = DATA_W / WORD_W;
    localparam int CNT_W   = $clog2(DATA_W) + 1;
    localparam int STAGES  = $clog2(DATA_W);
    localparam int SAD_W   = BYTE_W + $clog2(NUM_B);

    localparam logic [FUNC_W-1:0] FN_SEXT_B = 7'h00;
    localparam logic [FUNC_W-1:0] FN_SEXT_W = 7'h01;
    localparam logic [FUNC_W-1:0] FN_POP    = 7'h30;
    localparam logic [FUNC_W-1:0] FN_SAD    = 7'h31;
    localparam logic [FUNC_W-1:0] FN_LZ     = 7'h32;
    localparam logic [FUNC_W-1:0] FN_TZ     = 7'h33;
    localparam logic [FUNC_W-1:0] FN_UNP_W  = 7'h34;
    localparam logic [FUNC_W-1:0] FN_UNP_L  = 7'h35;
    localparam logic [FUNC_W-1:0] FN_PK_W   = 7'h36;
    localparam logic [FUNC_W-1:0] FN_PK_L   = 7'h37;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              illegal;
    } bcu_out_t;
endpackage

// File: rtl/bcu_count.sv
module bcu_count
    import bcu_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    output logic [CNT_W-1:0]  pop_cnt,
    output logic [CNT_W-1:0]  lead_cnt,
    output logic [CNT_W-1:0]  trail_cnt
);
    logic [DATA_W-1:0] lz_scan;
    logic [DATA_W-1:0] tz_scan;

    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pop_cnt = pop_cnt + CNT_W'(val[i]);
        end
    end

    // binary halving search from the top
    always_comb begin
        lz_scan  = val;
        lead_cnt = '0;
        for (int s = STAGES - 1; s >= 0; s--) begin
            if ((lz_scan >> (DATA_W - (1 << s))) == '0) begin
                lead_cnt = lead_cnt + CNT_W'(1 << s);
                lz_scan  = lz_scan << (1 << s);
            end
        end
        if (!lz_scan[DATA_W-1]) lead_cnt = lead_cnt + CNT_W'(1);
    end

    // binary halving search from the bottom
    always_comb begin
        tz_scan   = val;
        trail_cnt = '0;
        for (int s = STAGES - 1; s >= 0; s--) begin
            if ((tz_scan & ((DATA_W'(1) << (1 << s)) - DATA_W'(1))) == '0) begin
                trail_cnt = trail_cnt + CNT_W'(1 << s);
                tz_scan   = tz_scan >> (1 << s);
            end
        end
        if (!tz_scan[0]) trail_cnt = trail_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/bcu_lanes.sv
module bcu_lanes
    import bcu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sel_word,
    input  logic              sel_signed,
    input  logic              sel_max,
    output logic [DATA_W-1:0] minmax,
    output logic [SAD_W-1:0]  sad
);
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] word_res;
    logic [BYTE_W-1:0] absdiff [NUM_B];

    for (genvar i = 0; i < NUM_B; i++) begin : g_byte
        logic [BYTE_W-1:0] la, lb;
        logic              a_lt, a_gt;
        assign la   = a[i*BYTE_W +: BYTE_W];
        assign lb   = b[i*BYTE_W +: BYTE_W];
        assign a_lt = sel_signed ? ($signed(la) < $signed(lb)) : (la < lb);
        assign a_gt = sel_signed ? ($signed(la) > $signed(lb)) : (la > lb);
        assign byte_res[i*BYTE_W +: BYTE_W] = (sel_max ? a_gt : a_lt) ? la : lb;
        assign absdiff[i] = (la >= lb) ? (la - lb) : (lb - la);
    end

    for (genvar j = 0; j < NUM_W; j++) begin : g_word
        logic [WORD_W-1:0] la, lb;
        logic              a_lt, a_gt;
        assign la   = a[j*WORD_W +: WORD_W];
        assign lb   = b[j*WORD_W +: WORD_W];
        assign a_lt = sel_signed ? ($signed(la) < $signed(lb)) : (la < lb);
        assign a_gt = sel_signed ? ($signed(la) > $signed(lb)) : (la > lb);
        assign word_res[j*WORD_W +: WORD_W] = (sel_max ? a_gt : a_lt) ? la : lb;
    end

    assign minmax = sel_word ? word_res : byte_res;

    always_comb begin
        sad = '0;
        for (int k = 0; k < NUM_B; k++) begin
            sad = sad + SAD_W'(absdiff[k]);
        end
    end
endmodule

// File: rtl/bcu_pack.sv
module bcu_pack
    import bcu_pkg::*;
(
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sext_byte,
    output logic [DATA_W-1:0] sext_half,
    output logic [DATA_W-1:0] unpack_w,
    output logic [DATA_W-1:0] unpack_l,
    output logic [DATA_W-1:0] pack_w,
    output logic [DATA_W-1:0] pack_l
);
    localparam int PER_W = WORD_W / BYTE_W;
    localparam int PER_L = 2 * WORD_W / BYTE_W;

    assign sext_byte = {{(DATA_W-BYTE_W){b[BYTE_W-1]}}, b[BYTE_W-1:0]};
    assign sext_half = {{(DATA_W-WORD_W){b[WORD_W-1]}}, b[WORD_W-1:0]};

    always_comb begin
        unpack_w = '0;
        pack_w   = '0;
        for (int i = 0; i < NUM_B / PER_W; i++) begin
            unpack_w[i*WORD_W +: BYTE_W] = b[i*BYTE_W +: BYTE_W];
            pack_w[i*BYTE_W +: BYTE_W]   = b[i*WORD_W +: BYTE_W];
        end
        unpack_l = '0;
        pack_l   = '0;
        for (int i = 0; i < NUM_B / PER_L; i++) begin
            unpack_l[i*2*WORD_W +: BYTE_W] = b[i*BYTE_W +: BYTE_W];
            pack_l[i*BYTE_W +: BYTE_W]     = b[i*2*WORD_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/bcu_unit.sv
module bcu_unit
    import bcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [6:0]        func,
    input  logic              a_is_r31,
    output logic [63:0]       result,
    output logic              illegal
);
    logic [CNT_W-1:0]  pop_cnt, lead_cnt, trail_cnt;
    logic [DATA_W-1:0] minmax;
    logic [SAD_W-1:0]  sad;
    logic [DATA_W-1:0] sext_byte, sext_half, unpack_w, unpack_l, pack_w, pack_l;
    logic              sel_signed;
    bcu_out_t          out_d, out_q;

    // min codes: bit1 set means unsigned; max codes: bit1 set means signed
    assign sel_signed = (func[1] == func[2]);

    bcu_count u_count (
        .val       (op_b),
        .pop_cnt   (pop_cnt),
        .lead_cnt  (lead_cnt),
        .trail_cnt (trail_cnt)
    );

    bcu_lanes u_lanes (
        .a          (op_a),
        .b          (op_b),
        .sel_word   (func[0]),
        .sel_signed (sel_signed),
        .sel_max    (func[2]),
        .minmax     (minmax),
        .sad        (sad)
    );

    bcu_pack u_pack (
        .b         (op_b),
        .sext_byte (sext_byte),
        .sext_half (sext_half),
        .unpack_w  (unpack_w),
        .unpack_l  (unpack_l),
        .pack_w    (pack_w),
        .pack_l    (pack_l)
    );

    always_comb begin
        out_d = '0;
        unique case (func)
            FN_SEXT_B: if (a_is_r31) out_d.result = sext_byte; else out_d.illegal = 1'b1;
            FN_SEXT_W: if (a_is_r31) out_d.result = sext_half; else out_d.illegal = 1'b1;
            FN_POP:    out_d.result = DATA_W'(pop_cnt);
            FN_SAD:    out_d.result = DATA_W'(sad);
            FN_LZ:     out_d.result = DATA_W'(lead_cnt);
            FN_TZ:     out_d.result = DATA_W'(trail_cnt);
            FN_UNP_W:  out_d.result = unpack_w;
            FN_UNP_L:  out_d.result = unpack_l;
            FN_PK_W:   out_d.result = pack_w;
            FN_PK_L:   out_d.result = pack_l;
            7'h38, 7'h39, 7'h3a, 7'h3b,
            7'h3c, 7'h3d, 7'h3e, 7'h3f:
                       out_d.result = minmax;
            default:   out_d.illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result  = out_q.result;
    assign illegal = out_q.illegal;
endmodule

// File: rtl/bcu_unit_chk.sv
module bcu_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_b,
    input logic [6:0]  func,
    input logic        a_is_r31,
    input logic [63:0] result,
    input logic        illegal
);
    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == 64'd0));

    assert_pop_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h30) |-> (result <= 64'd64));

    assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h32 && $past(op_b) == 64'd0) |-> (result == 64'd64));

    assert_trail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h33 && $past(op_b) == 64'd0) |-> (result == 64'd64));

    assert_sad_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h31) |-> (result <= 64'd2040));

    assert_sext_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h00 && $past(a_is_r31))
            |-> (result[63:7] == '0 || result[63:7] == '1));

    assert_sext_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func) == 7'h01 && !$past(a_is_r31)) |-> illegal);
endmodule

bind bcu_unit bcu_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_b     (op_b),
    .func     (func),
    .a_is_r31 (a_is_r31),
    .result   (result),
    .illegal  (illegal)
);

// File: tb/bcu_unit_tb.sv
module bcu_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] op_a = 0, op_b = 0;
    logic [6:0]  func = 0;
    logic        a_is_r31 = 0;
    logic [63:0] result;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;

    bcu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .func(func), .a_is_r31(a_is_r31), .result(result), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(input logic [6:0] f, input logic r31);
        if ((f == 7'h00 || f == 7'h01) && !r31) return "R11";
        case (f)
            7'h00, 7'h01: return "R10";
            7'h30: return "R2";
            7'h31: return "R5";
            7'h32: return "R3";
            7'h33: return "R4";
            7'h34, 7'h35: return "R8";
            7'h36, 7'h37: return "R9";
            7'h38, 7'h39, 7'h3a, 7'h3b: return "R6";
            7'h3c, 7'h3d, 7'h3e, 7'h3f: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [64:0] ref_model(input logic [6:0] f, input logic [63:0] a,
                                              input logic [63:0] b, input logic r31);
        logic [63:0] r = 0;
        int cnt = 0;
        int lw;
        bit sg, mx;
        case (f)
            7'h00: if (r31) r = {{56{b[7]}}, b[7:0]};   else return {64'd0, 1'b1};
            7'h01: if (r31) r = {{48{b[15]}}, b[15:0]}; else return {64'd0, 1'b1};
            7'h30: begin for (int i = 0; i < 64; i++) cnt += b[i]; r = 64'(cnt); end
            7'h32: begin cnt = 64; for (int i = 0; i < 64; i++) if (b[i]) cnt = 63 - i; r = 64'(cnt); end
            7'h33: begin cnt = 64; for (int i = 63; i >= 0; i--) if (b[i]) cnt = i; r = 64'(cnt); end
            7'h31: begin
                for (int i = 0; i < 8; i++) begin
                    int x = int'(a[8*i +: 8]);
                    int y = int'(b[8*i +: 8]);
                    cnt += (x > y) ? x - y : y - x;
                end
                r = 64'(cnt);
            end
            7'h34: r = {8'h0, b[31:24], 8'h0, b[23:16], 8'h0, b[15:8], 8'h0, b[7:0]};
            7'h35: r = {24'h0, b[15:8], 24'h0, b[7:0]};
            7'h36: r = {32'h0, b[55:48], b[39:32], b[23:16], b[7:0]};
            7'h37: r = {48'h0, b[39:32], b[7:0]};
            7'h38, 7'h39, 7'h3a, 7'h3b, 7'h3c, 7'h3d, 7'h3e, 7'h3f: begin
                lw = f[0] ? 16 : 8;
                mx = f[2];
                sg = (f == 7'h38 || f == 7'h39 || f == 7'h3e || f == 7'h3f);
                for (int i = 0; i < 64 / lw; i++) begin
                    longint x = 0, y = 0;
                    for (int k = 0; k < lw; k++) begin
                        x[k] = a[i*lw + k];
                        y[k] = b[i*lw + k];
                    end
                    if (sg && x[lw-1]) x = x - (longint'(1) << lw);
                    if (sg && y[lw-1]) y = y - (longint'(1) << lw);
                    for (int k = 0; k < lw; k++)
                        r[i*lw + k] = (mx ? (x > y) : (x < y)) ? a[i*lw + k] : b[i*lw + k];
                end
            end
            default: return {64'd0, 1'b1};
        endcase
        return {r, 1'b0};
    endfunction

    task automatic run(input logic [6:0] f, input logic [63:0] a,
                       input logic [63:0] b, input logic r31);
        logic [64:0] exp;
        @(negedge clk);
        func = f; op_a = a; op_b = b; a_is_r31 = r31;
        exp = ref_model(f, a, b, r31);
        @(negedge clk);
        n_cmp++;
        if ({result, illegal} !== exp) begin
            n_bad++;
            $display("FAIL %s func=%h a=%h b=%h: got %h/%b exp %h/%b (R12 timing)",
                     req_of(f, r31), f, a, b, result, illegal, exp[64:1], exp[0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] legal [18];
        void'($urandom(32'h5eed));
        legal[0] = 7'h00; legal[1] = 7'h01;
        for (int i = 0; i < 16; i++) legal[i+2] = 7'(7'h30 + i);

        // R1: reset state, even with a legal function on the inputs
        func = 7'h30; op_b = '1;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result !== 64'd0 || illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got %h/%b exp 0/0", result, illegal);
        end
        rst_n = 1;

        // directed corner cases
        run(7'h32, 64'd0, 64'd0, 0);                    // R3 zero
        run(7'h33, 64'd0, 64'd0, 0);                    // R4 zero
        run(7'h32, 64'd0, 64'h8000_0000_0000_0000, 0);  // R3
        run(7'h33, 64'd0, 64'h8000_0000_0000_0000, 0);  // R4
        run(7'h32, 64'd0, 64'd1, 0);                    // R3
        run(7'h33, 64'd0, 64'd1, 0);                    // R4
        for (int i = 0; i < 64; i++) begin
            run(7'h32, 64'd0, 64'd1 << i, 0);
            run(7'h33, 64'd0, 64'd1 << i, 0);
        end
        run(7'h30, 64'd0, '1, 0);                       // R2 all ones
        run(7'h30, 64'd0, 64'd0, 0);                    // R2
        run(7'h31, 64'd0, '1, 0);                       // R5 maximum
        run(7'h31, '1, 64'd0, 0);                       // R5
        run(7'h38, 64'h7f80_7f80_0000_ff01, 64'h807f_807f_0000_01ff, 0); // R6
        run(7'h3a, 64'h7f80_7f80_0000_ff01, 64'h807f_807f_0000_01ff, 0); // R6
        run(7'h3f, 64'h8000_7fff_1234_ffff, 64'h7fff_8000_1234_0000, 0); // R7
        run(7'h3d, 64'h8000_7fff_1234_ffff, 64'h7fff_8000_1234_0000, 0); // R7
        run(7'h34, 64'd0, 64'h1122_3344_5566_7788, 0);  // R8
        run(7'h35, 64'd0, 64'h1122_3344_5566_7788, 0);  // R8
        run(7'h36, 64'd0, 64'h1122_3344_5566_7788, 0);  // R9
        run(7'h37, 64'd0, 64'h1122_3344_5566_7788, 0);  // R9
        run(7'h00, 64'd0, 64'h0000_0000_0000_0080, 1);  // R10
        run(7'h01, 64'd0, 64'h0000_0000_0000_7fff, 1);  // R10
        run(7'h00, 64'd0, 64'h0000_0000_0000_0080, 0);  // R11
        run(7'h01, 64'd0, 64'hffff, 0);                 // R11
        run(7'h02, '1, '1, 1);                          // R11
        run(7'h7f, '1, '1, 1);                          // R11

        // constrained random mix
        for (int n = 0; n < 2000; n++) begin
            logic [6:0] f;
            logic [63:0] a, b;
            f = ($urandom_range(0, 9) == 0) ? 7'($urandom) : legal[$urandom_range(0, 17)];
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) b = b >> $urandom_range(0, 63);
            run(f, a, b, 1'($urandom_range(0, 3) != 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule